// File: doc/BRIEF.md
# Aliased Set/Clear/Toggle Control Register Bank

This block is the control and status register file of a peripheral. Each logical 32-bit register can be reached through four neighbouring word addresses. One of them replaces the register contents. The other three change only the bits that carry a one in the write data: they set them, clear them or invert them. Software can therefore change a single control bit with one write, without a read-modify-write sequence that could race with another agent.

The bank talks to a simple synchronous bus slave port. The port has a select, a write enable, a word address, write data, and registered read data with a ready flag. It drives every register's contents in parallel to the peripheral core. The two top bits of register 0 are reserved in every instance of the bank. Bit 31 puts the core and all other registers into soft reset. Bit 30 gates the core clock, and it powers up set so the core starts gated. Read-only status bits come from the core and show through in the readable view of registers 1 and up.

Top module: `alias_regbank`

## Requirements
- R1: The word address splits into a register index (upper bits) and an alias code (bits 1:0), so register n starts at byte offset n*0x10. Alias code 0 writes the value, 1 sets, 2 clears and 3 toggles.
- R2: A write through alias code 0 replaces every writable bit of the register with the write data.
- R3: A write through the set alias makes every bit written as one equal to one and leaves all other bits unchanged.
- R4: A write through the clear alias makes every bit written as one equal to zero and leaves all other bits unchanged.
- R5: A write through the toggle alias inverts every bit written as one and leaves all other bits unchanged.
- R6: A read through any of a register's four alias addresses returns the register's current view. A read never changes any register.
- R7: An index at or above NUM_REGS reads as zero, and a write to it changes no register.
- R8: ready_o is high exactly one cycle after a cycle with sel_i high, and rdata_o holds the value from that access. A write shows on regs_o right after its clock edge and in the next read.
- R9: While register 0 bit 31 is one, core_rst_o is high and every register except register 0 bits 31:30 holds its reset value. A write that sets bit 31 clears the other bits at the same edge.
- R10: core_clken_o is the inverse of register 0 bit 30. After hardware reset, register 0 reads 0x4000_0000 (gated, not in soft reset) and the other registers read zero in their writable bits.
- R11: For registers 1 and up, the bits set in RO_MASK (default 0xFF00_0000) always read from that register's 32-bit slice of status_i, and no alias write changes them. Register 0 has no status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| sel_i | input | 1 | Bus access request this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address: register index and alias code |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ready_o | output | 1 | Access completed (one cycle after sel_i) |
| status_i | input | NUM_REGS*32 | Core status, one 32-bit slice per register |
| regs_o | output | NUM_REGS*32 | Readable view of every register, to the core |
| core_rst_o | output | 1 | Soft reset to the core |
| core_clken_o | output | 1 | Clock enable to the core |

## Verification
Every mapped register and two unmapped indices receive each alias code with all-ones, all-zero and several scattered bit patterns. After each write the register is read back through a rotating alias. The all-ones and all-zero words tell the set and clear aliases apart from a plain write. The scattered words expose a toggle that acts on the wrong bits, and the rotating alias shows that a read depends only on the index. Separate sequences set the soft reset with data already loaded and change the status input under toggle writes, which shows the reset holding the registers and the read-only bits surviving writes.

// File: rtl/alias_regbank_pkg.sv
package alias_regbank_pkg;

    localparam int WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLR   = 2'd2,
        OP_TOG   = 2'd3
    } alias_op_e;

    // Register 0 bits owned by the soft reset (31) and clock gate (30)
    localparam word_t CTRL_MASK = 32'hC000_0000;
    localparam word_t CTRL_RST  = 32'h4000_0000;

    typedef struct packed {
        logic  ready;
        word_t rdata;
    } bus_state_t;

    function automatic word_t alias_apply(input alias_op_e op, input word_t cur, input word_t wd);
        word_t r;
        unique case (op)
            OP_WRITE: r = wd;
            OP_SET:   r = cur | wd;
            OP_CLR:   r = cur & ~wd;
            OP_TOG:   r = cur ^ wd;
            default:  r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alias_regbank_decode.sv
module alias_regbank_decode
    import alias_regbank_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 6,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic                sel_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [NUM_REGS-1:0] wr_o,
    output alias_op_e           op_o,
    output logic [IDX_W-1:0]    idx_o
);

    always_comb begin
        idx_o = addr_i[ADDR_W-1:2];
        op_o  = alias_op_e'(addr_i[1:0]);
    end

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_wr
        assign wr_o[k] = sel_i && we_i && (idx_o == IDX_W'(k));
    end

endmodule

// File: rtl/alias_regbank_cell.sv
module alias_regbank_cell
    import alias_regbank_pkg::*;
#(
    parameter bit    IS_CTRL = 1'b0,
    parameter word_t RST_VAL = '0,
    parameter word_t RO_MASK = '0
) (
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      wr_i,
    input  alias_op_e op_i,
    input  word_t     wdata_i,
    input  logic      hold_i,
    input  word_t     status_i,
    output word_t     value_o,
    output word_t     view_o,
    output logic      srst_nxt_o
);

    localparam word_t WMASK = ~RO_MASK;

    word_t val_d, val_q, upd;
    logic  srst_nxt;

    always_comb begin
        upd      = wr_i ? alias_apply(op_i, val_q, wdata_i) : val_q;
        upd      = upd & WMASK;
        val_d    = upd;
        srst_nxt = 1'b0;
        if (IS_CTRL) begin
            srst_nxt = upd[WORD_W-1];
            if (srst_nxt) begin
                val_d = (upd & CTRL_MASK) | (RST_VAL & ~CTRL_MASK);
            end
        end
        if (hold_i) begin
            val_d = RST_VAL & WMASK;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            val_q <= RST_VAL & WMASK;
        end else begin
            val_q <= val_d;
        end
    end

    assign value_o    = val_q;
    assign view_o     = (val_q & WMASK) | (status_i & RO_MASK);
    assign srst_nxt_o = srst_nxt;

    // R2
    write_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && op_i == OP_WRITE && !hold_i && !srst_nxt) |=> (val_q == ($past(wdata_i) & WMASK)));

    // R3
    set_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && op_i == OP_SET && !hold_i && !srst_nxt)
        |=> ((val_q & $past(wdata_i) & WMASK) == ($past(wdata_i) & WMASK))
            && ((val_q & ~$past(wdata_i)) == ($past(val_q) & ~$past(wdata_i))));

    // R4
    clr_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && op_i == OP_CLR && !hold_i && !srst_nxt)
        |=> ((val_q & $past(wdata_i)) == '0)
            && ((val_q & ~$past(wdata_i)) == ($past(val_q) & ~$past(wdata_i))));

    // R5
    tog_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && op_i == OP_TOG && !hold_i && !srst_nxt)
        |=> (val_q == (($past(val_q) ^ $past(wdata_i)) & WMASK)));

    // R9
    hold_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> (val_q == (RST_VAL & WMASK)));

    // R6
    no_write_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr_i && !hold_i && !srst_nxt) |=> $stable(val_q));

endmodule

// File: rtl/alias_regbank_rdmux.sv
module alias_regbank_rdmux
    import alias_regbank_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 4
) (
    input  logic [IDX_W-1:0]              idx_i,
    input  logic [NUM_REGS-1:0][WORD_W-1:0] views_i,
    output word_t                         data_o
);

    always_comb begin
        data_o = '0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (idx_i == IDX_W'(k)) begin
                data_o = data_o | views_i[k];
            end
        end
    end

endmodule

// File: rtl/alias_regbank.sv
module alias_regbank
    import alias_regbank_pkg::*;
#(
    parameter int    NUM_REGS = 4,
    parameter int    ADDR_W   = 6,
    parameter word_t RO_MASK  = 32'hFF00_0000
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       sel_i,
    input  logic                       we_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [WORD_W-1:0]          wdata_i,
    output logic [WORD_W-1:0]          rdata_o,
    output logic                       ready_o,
    input  logic [NUM_REGS*WORD_W-1:0] status_i,
    output logic [NUM_REGS*WORD_W-1:0] regs_o,
    output logic                       core_rst_o,
    output logic                       core_clken_o
);

    localparam int IDX_W = ADDR_W - 2;

    logic [NUM_REGS-1:0]              wr_vec;
    alias_op_e                        op;
    logic [IDX_W-1:0]                 idx;
    logic [NUM_REGS-1:0][WORD_W-1:0]  views;
    logic [NUM_REGS-1:0][WORD_W-1:0]  values;
    logic [NUM_REGS-1:0]              srst_nxt;
    logic                             hold_others;
    word_t                            rd_word;
    bus_state_t                       st_d, st_q;

    alias_regbank_decode #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_dec (
        .sel_i  (sel_i),
        .we_i   (we_i),
        .addr_i (addr_i),
        .wr_o   (wr_vec),
        .op_o   (op),
        .idx_o  (idx)
    );

    assign hold_others = |srst_nxt;

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
        if (k == 0) begin : g_ctrl
            alias_regbank_cell #(
                .IS_CTRL (1'b1),
                .RST_VAL (CTRL_RST),
                .RO_MASK ('0)
            ) u_cell (
                .clk_i      (clk_i),
                .rst_ni     (rst_ni),
                .wr_i       (wr_vec[k]),
                .op_i       (op),
                .wdata_i    (wdata_i),
                .hold_i     (1'b0),
                .status_i   (status_i[k*WORD_W +: WORD_W]),
                .value_o    (values[k]),
                .view_o     (views[k]),
                .srst_nxt_o (srst_nxt[k])
            );
        end else begin : g_data
            alias_regbank_cell #(
                .IS_CTRL (1'b0),
                .RST_VAL ('0),
                .RO_MASK (RO_MASK)
            ) u_cell (
                .clk_i      (clk_i),
                .rst_ni     (rst_ni),
                .wr_i       (wr_vec[k]),
                .op_i       (op),
                .wdata_i    (wdata_i),
                .hold_i     (hold_others),
                .status_i   (status_i[k*WORD_W +: WORD_W]),
                .value_o    (values[k]),
                .view_o     (views[k]),
                .srst_nxt_o (srst_nxt[k])
            );
        end
    end

    alias_regbank_rdmux #(
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_rdmux (
        .idx_i   (idx),
        .views_i (views),
        .data_o  (rd_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ready = sel_i;
        if (sel_i && !we_i) begin
            st_d.rdata = rd_word;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata_o      = st_q.rdata;
    assign ready_o      = st_q.ready;
    assign regs_o       = views;
    assign core_rst_o   = values[0][WORD_W-1];
    assign core_clken_o = ~values[0][WORD_W-2];

    // R8
    ready_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_i |=> ready_o);

    // R8
    ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_i |=> !ready_o);

    // R7
    unmapped_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && we_i && idx >= IDX_W'(NUM_REGS) && !core_rst_o) |=> $stable(values));

    // R7
    unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && !we_i && idx >= IDX_W'(NUM_REGS)) |=> (rdata_o == '0));

    // R9
    soft_reset_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_rst_o |-> ((values[0] & ~CTRL_MASK) == (CTRL_RST & ~CTRL_MASK)));

endmodule

// File: tb/alias_regbank_test.sv
module alias_regbank_test;

    localparam int NR = 4;
    localparam int AW = 6;
    localparam logic [31:0] RO = 32'hFF00_0000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sel = 1'b0;
    logic            we = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            ready;
    logic [NR*32-1:0] status = '0;
    logic [NR*32-1:0] regs;
    logic            core_rst;
    logic            core_clken;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model [NR];
    bit done = 1'b0;

    always #2 clk = ~clk;

    alias_regbank #(.NUM_REGS(NR), .ADDR_W(AW), .RO_MASK(RO)) uut (
        .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready), .status_i(status),
        .regs_o(regs), .core_rst_o(core_rst), .core_clken_o(core_clken)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] view_of(input int k);
        if (k == 0) return model[0];
        return (model[k] & ~RO) | (status[k*32 +: 32] & RO);
    endfunction

    function automatic logic [31:0] op_apply(input int op, input logic [31:0] c, input logic [31:0] w);
        case (op)
            0: return w;
            1: return c | w;
            2: return c & ~w;
            default: return c ^ w;
        endcase
    endfunction

    function automatic void model_write(input int idx, input int op, input logic [31:0] w);
        logic [31:0] nv;
        if (idx >= NR) return;
        if (idx == 0) begin
            nv = op_apply(op, model[0], w);
            if (nv[31]) begin
                model[0] = (nv & 32'hC000_0000);
                for (int k = 1; k < NR; k++) model[k] = '0;
            end else begin
                model[0] = nv;
            end
        end else if (!model[0][31]) begin
            model[idx] = op_apply(op, model[idx], w) & ~RO;
        end
    endfunction

    task automatic do_write(input int idx, input int op, input logic [31:0] w);
        @(negedge clk);
        sel = 1'b1; we = 1'b1; addr = AW'(idx * 4 + op); wdata = w;
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
        model_write(idx, op, w);
    endtask

    task automatic do_read(input int idx, input int op, input string req);
        logic [31:0] exp;
        @(negedge clk);
        sel = 1'b1; we = 1'b0; addr = AW'(idx * 4 + op);
        exp = (idx < NR) ? view_of(idx) : 32'h0;
        @(negedge clk);
        sel = 1'b0;
        check("R8 ready", {31'b0, ready}, 32'h1);
        check(req, rdata, exp);
    endtask

    task automatic check_outputs(input string req);
        for (int k = 0; k < NR; k++) check(req, regs[k*32 +: 32], view_of(k));
        check("R10 clken", {31'b0, core_clken}, {31'b0, ~model[0][30]});
        check("R9 core_rst", {31'b0, core_rst}, {31'b0, model[0][31]});
    endtask

    initial begin
        for (int k = 0; k < NR; k++) model[k] = '0;
        model[0] = 32'h4000_0000;
        for (int k = 0; k < NR; k++) status[k*32 +: 32] = 32'hA5C3_0F00 ^ (32'h1111_1111 * k);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 reset ready", {31'b0, ready}, 32'h0);
        check_outputs("R10 reset view");
        do_read(0, 0, "R10 reset reg0");

        // R1..R7 sweep: every index (two unmapped), every alias, several patterns
        for (int r = 0; r < 6; r++) begin
            for (int op = 0; op < 4; op++) begin
                for (int k = 0; k < 6; k++) begin
                    int idx;
                    logic [31:0] w;
                    idx = (r < NR) ? r : ((r == NR) ? NR : 15);
                    if (k == 0) w = 32'hFFFF_FFFF;
                    else if (k == 1) w = 32'h0;
                    else w = (32'h9E37_79B9 * (k * 7 + op * 3 + r + 1)) ^ (32'h1 << ((k * 5) % 32));
                    if (idx == 0) w[31] = 1'b0;
                    do_write(idx, op, w);
                    check_outputs(op == 0 ? "R2 write" : op == 1 ? "R3 set" : op == 2 ? "R4 clr" : "R5 tog");
                    do_read(idx, (op + k) % 4, idx >= NR ? "R7 unmapped read" : "R1 R6 alias read");
                end
            end
        end

        // R6: reads have no side effects
        do_write(2, 0, 32'h0012_3456);
        do_read(2, 1, "R6 read");
        do_read(2, 2, "R6 read");
        do_read(2, 3, "R6 read");
        check_outputs("R6 after reads");

        // R11: status bits ignore writes and follow the input
        do_write(1, 3, 32'hFFFF_FFFF);
        do_write(3, 1, 32'hFFFF_FFFF);
        status[1*32 +: 32] = 32'h5A00_0000;
        status[3*32 +: 32] = 32'h8100_0000;
        @(negedge clk);
        check_outputs("R11 status");
        do_read(1, 0, "R11 ro read");
        do_read(3, 2, "R11 ro read");

        // R9: soft reset with data loaded
        do_write(1, 0, 32'h00AB_CDEF);
        do_write(0, 2, 32'h4000_0000);
        do_write(0, 0, 32'h0000_1234);
        do_write(0, 1, 32'h8000_0000);
        check_outputs("R9 soft reset entry");
        do_write(2, 0, 32'h00FF_FFFF);
        check_outputs("R9 write held");
        do_read(2, 0, "R9 read held");
        do_write(0, 0, 32'h8000_5555);
        check_outputs("R9 reg0 low held");
        do_write(0, 2, 32'h8000_0000);
        do_write(2, 0, 32'h0033_0033);
        check_outputs("R9 release");
        do_read(2, 3, "R9 after release");
        do_write(0, 3, 32'h4000_0000);
        check_outputs("R10 gate toggle");

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule